// File: doc/BRIEF.md
# Cascaded Match-Device Response Arbiter

Each device in a chain of cascaded associative-memory parts carries this arbiter. While the active-low strobe is low, it decides whether the local core may act on a read, a data write or a command write. The decision depends on three things. The first is a chain lock state. The lock is sampled from the active-low chain-enable and takes effect one access late. The second is whether this device holds the highest-priority match. The third is whether it holds the first free location of the chain. A mode bit picks standard or enhanced rules. In enhanced mode a locked chain no longer blocks writes after a failed compare.

The strobe is an input that is sampled on `clk`. A two-state phase machine follows it. `PH_IDLE` moves to `PH_ACCESS` on the transition *strobe-fall*, when the strobe is seen low. On that transition chain-enable is captured. `PH_ACCESS` moves back to `PH_IDLE` on the transition *strobe-rise*, when the strobe is seen high. On that transition the captured value moves into the lock machine. The lock machine has two states. `LK_OPEN` moves to `LK_HELD` on *lock-take*, which happens when the captured value was low. `LK_HELD` moves to `LK_OPEN` on *lock-release*, which happens when the captured value was high. Each lock state holds unless one of these transitions occurs.

The operation class input uses these codes:

| Code | Meaning |
|------|---------|
| 0 | read |
| 1 | data write |
| 2 | command write |
| 3 | write, move or validity operation on the highest-match location |
| 4 | write or move into the next free location |
| 5 to 7 | unused |

Top module: `casc_rsp_arbiter`

## Requirements
- R1: Chain-enable is captured at the clock that first sees the strobe low. It is applied to the lock at the clock that first sees the strobe high again. It therefore governs the next access, and its level during the current access has no effect on that access.
- R2: While the lock is open, an access is granted when `dsel_all_i` is 1 and the target rule below is met.
- R3: The chain stays locked for every later access whose strobe fall sees chain-enable low.
- R4: In standard mode with the lock held, only a device with both `match_i` and `hpm_i` at 1 grants any class.
- R5: In standard mode with the lock held and no match, nothing is granted. An access whose strobe fall sees chain-enable high releases the lock for the following access. That unlocking access itself executes only in a highest-match device.
- R6: In enhanced mode with the lock held, classes 1 and 2 are granted in every device, regardless of match or `dsel_all_i`.
- R7: In enhanced mode with the lock held, class 3 is granted only with `match_i` and `hpm_i` at 1, and class 0 likewise.
- R8: Class 4 is granted only when `full_in_n` is 0 and `full_out_n` is 1. This holds in every mode and lock state.
- R9: Enables are produced only while `strb_n` is 0. `rd_en_o` is for class 0 only. `wr_en_o` is for classes 1 to 4 only. The two are never both 1, and classes 5 to 7 get neither.
- R10: A synchronous reset opens the lock, sets the captured value high and selects standard mode. With chain-enable tied high, the lock never closes.
- R11: `mode_enh_i` is registered on each clock. A change takes effect from the clock after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| strb_n | input | 1 | active-low access strobe |
| chain_en_n | input | 1 | active-low chain enable |
| mode_enh_i | input | 1 | 1 selects enhanced mode |
| op_cls_i | input | 3 | operation class code |
| match_i | input | 1 | local match flag |
| hpm_i | input | 1 | highest-priority-match indication from the chain |
| full_in_n | input | 1 | full-in from the upstream device, active low |
| full_out_n | input | 1 | this device's full-out, active low |
| dsel_all_i | input | 1 | device-select register holds all ones |
| rd_en_o | output | 1 | read qualifier to the core |
| wr_en_o | output | 1 | write qualifier to the core |

## Verification
Two events can fall in the same access. One is the lock release caused by chain-enable going high. The other is the execution of the instruction that performs the release. The bench locks the chain with no match and then issues an access with chain-enable high. It checks that this access is still refused when there is no match, and granted only when match and highest-match are both 1. It then checks that the next access sees the open lock. A second collision is a mode change applied together with a strobe fall. For that case the output is sampled before and after the next clock to confirm the one-clock delay.

// File: rtl/casc_rsp_pkg.sv
package casc_rsp_pkg;
    localparam int OPC_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OPC_READ   = 3'd0,
        OPC_DWRITE = 3'd1,
        OPC_CWRITE = 3'd2,
        OPC_HMATCH = 3'd3,
        OPC_NFREE  = 3'd4
    } opc_e;

    typedef enum logic {PH_IDLE, PH_ACCESS} phase_e;
    typedef enum logic {LK_OPEN, LK_HELD} lock_e;
endpackage

// File: rtl/casc_rsp_sequencer.sv
module casc_rsp_sequencer
    import casc_rsp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  strb_n,
    input  logic  chain_en_n,
    input  logic  mode_enh_i,
    output lock_e lock_o,
    output logic  enh_o,
    output logic  access_o
);
    phase_e ph_q, ph_d;
    lock_e  lock_q;
    logic   cap_q;
    logic   enh_q;
    logic   strobe_fall, strobe_rise;

    // phase state register
    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_IDLE;
        else     ph_q <= ph_d;
    end

    // phase next-state and edge events
    always_comb begin
        ph_d        = ph_q;
        strobe_fall = 1'b0;
        strobe_rise = 1'b0;
        unique case (ph_q)
            PH_IDLE: if (!strb_n) begin
                ph_d        = PH_ACCESS;
                strobe_fall = 1'b1;
            end
            PH_ACCESS: if (strb_n) begin
                ph_d        = PH_IDLE;
                strobe_rise = 1'b1;
            end
        endcase
    end

    // capture at strobe fall, lock update at strobe rise, mode register
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q  <= 1'b1;
            lock_q <= LK_OPEN;
            enh_q  <= 1'b0;
        end else begin
            enh_q <= mode_enh_i;
            if (strobe_fall) cap_q <= chain_en_n;
            if (strobe_rise) lock_q <= cap_q ? LK_OPEN : LK_HELD;
        end
    end

    assign lock_o   = lock_q;
    assign enh_o    = enh_q;
    assign access_o = ~strb_n;

    // lock moves only on a strobe rise
    assert_lock_only_at_rise_R1: assert property (@(posedge clk) disable iff (rst)
        !strobe_rise |=> $stable(lock_q));
    // a held-low capture keeps the chain locked
    assert_low_capture_locks_R3: assert property (@(posedge clk) disable iff (rst)
        (strobe_rise && !cap_q) |=> lock_q == LK_HELD);
    // a high capture releases the lock
    assert_high_capture_opens_R5: assert property (@(posedge clk) disable iff (rst)
        (strobe_rise && cap_q) |=> lock_q == LK_OPEN);
    // mode follows its input one clock later
    assert_mode_delay_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> enh_q == $past(mode_enh_i));
endmodule

// File: rtl/casc_rsp_policy.sv
module casc_rsp_policy
    import casc_rsp_pkg::*;
(
    input  lock_e            lock_i,
    input  logic             enh_i,
    input  logic             access_i,
    input  logic [OPC_W-1:0] op_i,
    input  logic             match_i,
    input  logic             hpm_i,
    input  logic             full_in_n,
    input  logic             full_out_n,
    input  logic             dsel_all_i,
    output logic             rd_en_o,
    output logic             wr_en_o
);
    localparam int unsigned OPC_LAST = 4;

    logic hp_ok, nf_ok, tgt_ok, grant, is_rd, known;

    always_comb begin
        hp_ok = match_i & hpm_i;
        nf_ok = ~full_in_n & full_out_n;
        case (op_i)
            OPC_HMATCH: tgt_ok = hp_ok;
            OPC_NFREE:  tgt_ok = nf_ok;
            default:    tgt_ok = 1'b1;
        endcase
        if (lock_i == LK_OPEN) begin
            grant = dsel_all_i & tgt_ok;
        end else if (!enh_i) begin
            grant = hp_ok & tgt_ok;
        end else begin
            case (op_i)
                OPC_READ:               grant = hp_ok;
                OPC_DWRITE, OPC_CWRITE: grant = 1'b1;
                default:                grant = tgt_ok;
            endcase
        end
        is_rd   = (op_i == OPC_READ);
        known   = (32'(op_i) <= OPC_LAST);
        rd_en_o = access_i & grant & is_rd;
        wr_en_o = access_i & grant & ~is_rd & known;
    end
endmodule

// File: rtl/casc_rsp_arbiter.sv
module casc_rsp_arbiter
    import casc_rsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             strb_n,
    input  logic             chain_en_n,
    input  logic             mode_enh_i,
    input  logic [OPC_W-1:0] op_cls_i,
    input  logic             match_i,
    input  logic             hpm_i,
    input  logic             full_in_n,
    input  logic             full_out_n,
    input  logic             dsel_all_i,
    output logic             rd_en_o,
    output logic             wr_en_o
);
    lock_e lock_s;
    logic  enh_s, access_s;

    casc_rsp_sequencer seq_i (
        .clk        (clk),
        .rst        (rst),
        .strb_n     (strb_n),
        .chain_en_n (chain_en_n),
        .mode_enh_i (mode_enh_i),
        .lock_o     (lock_s),
        .enh_o      (enh_s),
        .access_o   (access_s)
    );

    casc_rsp_policy pol_i (
        .lock_i     (lock_s),
        .enh_i      (enh_s),
        .access_i   (access_s),
        .op_i       (op_cls_i),
        .match_i    (match_i),
        .hpm_i      (hpm_i),
        .full_in_n  (full_in_n),
        .full_out_n (full_out_n),
        .dsel_all_i (dsel_all_i),
        .rd_en_o    (rd_en_o),
        .wr_en_o    (wr_en_o)
    );

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(rd_en_o && wr_en_o));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        strb_n |-> (!rd_en_o && !wr_en_o));
    assert_std_locked_hp_R4: assert property (@(posedge clk) disable iff (rst)
        (lock_s == LK_HELD && !enh_s && !(match_i && hpm_i)) |-> (!rd_en_o && !wr_en_o));
    assert_nfree_chain_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && op_cls_i == OPC_NFREE) |-> (!full_in_n && full_out_n));
    assert_hmatch_only_hp_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && op_cls_i == OPC_HMATCH) |-> (match_i && hpm_i));
endmodule

// File: tb/casc_rsp_arbiter_tb.sv
module casc_rsp_arbiter_tb_top;
    localparam int NVEC = 18;
    localparam int WDOG = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strb_n = 1'b1, chain_en_n = 1'b1, mode_enh = 1'b0;
    logic [2:0] op = 3'd0;
    logic match = 1'b0, hpm = 1'b0, fi_n = 1'b1, ff_n = 1'b1, dsel = 1'b1;
    logic rd_en, wr_en;
    int errors = 0, checks = 0;

    always #10 clk = ~clk;

    casc_rsp_arbiter dut_i (
        .clk(clk), .rst(rst), .strb_n(strb_n), .chain_en_n(chain_en_n),
        .mode_enh_i(mode_enh), .op_cls_i(op), .match_i(match), .hpm_i(hpm),
        .full_in_n(fi_n), .full_out_n(ff_n), .dsel_all_i(dsel),
        .rd_en_o(rd_en), .wr_en_o(wr_en)
    );

    // {enh, setup_ce, op[2:0], match, hpm, fi_n, ff_n, dsel, exp_rd, exp_wr}
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b0,1'b1,3'd0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0}, // R2 open read
        {1'b0,1'b1,3'd1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0}, // R2 open, not selected
        {1'b0,1'b1,3'd3,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0}, // R2 open HM no match
        {1'b0,1'b1,3'd3,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1}, // R2 open HM match
        {1'b0,1'b1,3'd4,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1}, // R8 open NF first free
        {1'b0,1'b1,3'd4,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0}, // R8 open NF not first
        {1'b0,1'b0,3'd0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0}, // R4 locked read hp
        {1'b0,1'b0,3'd0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0}, // R4 locked match not hp
        {1'b0,1'b0,3'd1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0}, // R5 locked no match
        {1'b0,1'b0,3'd2,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1}, // R4 locked cmd hp
        {1'b1,1'b0,3'd1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1}, // R6 enh data write
        {1'b1,1'b0,3'd2,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1}, // R6 enh cmd write
        {1'b1,1'b0,3'd0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0}, // R7 enh read no match
        {1'b1,1'b0,3'd3,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0}, // R7 enh HM not hp
        {1'b1,1'b0,3'd3,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1}, // R7 enh HM hp
        {1'b1,1'b0,3'd4,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1}, // R8 enh NF first free
        {1'b1,1'b0,3'd4,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0}, // R8 enh NF full
        {1'b0,1'b0,3'd4,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1}  // R8 std locked NF hp
    };

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {rd,wr} actual=%b expected=%b", req, act, exp);
        end
    endtask

    // one access; outputs sampled during the strobe-low phase
    task automatic access(input logic ce, input logic [2:0] oc, input logic m, input logic h,
                          input logic fi, input logic ff, input logic ds,
                          output logic [1:0] got);
        @(negedge clk);
        chain_en_n = ce; op = oc; match = m; hpm = h; fi_n = fi; ff_n = ff; dsel = ds;
        strb_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        #1 got = {rd_en, wr_en};
        strb_n = 1'b1;
        @(posedge clk);
    endtask

    logic [1:0] r;

    initial begin
        #(WDOG * 20);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1 chk("R10 reset idle", {rd_en, wr_en}, 2'b00);
        access(1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, r);
        chk("R10 reset opens lock", r, 2'b10);

        for (int i = 0; i < NVEC; i++) begin
            logic [11:0] v;
            v = VEC[i];
            @(negedge clk) mode_enh = v[11];
            // setup access sets lock to v[10]; data chosen to do nothing
            access(v[10], 3'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, r);
            // test access uses the opposite chain-enable (R1: no effect now)
            access(~v[10], v[9:7], v[6], v[5], v[4], v[3], v[2], r);
            chk($sformatf("R1 vector %0d", i), r, v[1:0]);
        end

        // R3 / R5: lock, stay locked, unlock cycle, then open
        @(negedge clk) mode_enh = 1'b0;
        access(1'b0, 3'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, r);
        access(1'b0, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, r);
        chk("R3 locked access 1", r, 2'b00);
        access(1'b0, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, r);
        chk("R3 still locked", r, 2'b00);
        access(1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, r);
        chk("R5 unlock cycle no match", r, 2'b00);
        access(1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, r);
        chk("R5 after unlock", r, 2'b01);
        access(1'b0, 3'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, r);
        access(1'b1, 3'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, r);
        chk("R5 unlock cycle in hp device", r, 2'b01);

        // R9: strobe high gives nothing; unused class gives nothing
        @(negedge clk);
        op = 3'd1; match = 1'b1; hpm = 1'b1; dsel = 1'b1;
        #1 chk("R9 strobe high", {rd_en, wr_en}, 2'b00);
        access(1'b1, 3'd6, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, r);
        chk("R9 unused class", r, 2'b00);

        // R11: mode switched together with strobe fall
        access(1'b0, 3'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, r);
        @(negedge clk);
        chain_en_n = 1'b0; op = 3'd1; match = 1'b0; hpm = 1'b0; mode_enh = 1'b1;
        strb_n = 1'b0;
        #1 chk("R11 before mode clock", {rd_en, wr_en}, 2'b00);
        @(negedge clk);
        #1 chk("R11 after mode clock", {rd_en, wr_en}, 2'b01);
        strb_n = 1'b1;
        @(posedge clk);

        // R10: reset while locked restores open standard operation
        access(1'b0, 3'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, r);
        @(negedge clk) rst = 1'b1; mode_enh = 1'b0;
        @(negedge clk) rst = 1'b0;
        access(1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, r);
        chk("R10 reset while locked", r, 2'b10);

        // R10: chain-enable tied high never locks
        for (int k = 0; k < 4; k++) begin
            access(1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, r);
            chk("R10 tied high", r, 2'b01);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule